// File: doc/BRIEF.md
# Jitter Attenuator Elastic Buffer

This block smooths a serial bit stream whose arrival times jitter. Incoming bits, each marked by a one-cycle write strobe, enter a one-bit-wide elastic buffer. Read strobes from a phase-accumulator oscillator, running on the clean master clock, take them out again. The oscillator's step is its nominal increment plus a narrowband correction that is proportional to how far the fill level sits from half depth. Over time the read rate therefore tracks the average write rate, while short-term arrival jitter is absorbed by the buffer.

At the extremes the correction is set aside. A full buffer reads faster by a fixed parts-per-million offset and an empty buffer reads slower by the same offset, so input jitter passes through rather than data being lost. If the buffer overflows or underflows anyway, the full and empty flags are both raised and stay raised until they are cleared. A two-bit code selects the buffer depth, and a restricted strap mode limits that code to the two smallest depths. Two enables place the buffer in the receive stream or the transmit stream, or bypass it. The stream that is not attenuated passes straight through.

Top module: `jabuf_top`

## Requirements
- R1: The effective depth code selects 16, 32, 64 or 128 bits for codes 00, 01, 10 and 11. A recentred buffer holds depth/2 zero bits, so with no input exactly depth/2 read strobes appear before the empty flag rises.
- R2: With `pin_mode` high, `depth_sel[1]` is ignored, so only 16 (code x0) or 32 (code x1) bits are available.
- R3: With `tx_en` high the buffer sits in the transmit stream; with only `rx_en` high it sits in the receive stream; with both low it is bypassed and held idle with both flags low. Any stream not attenuated appears at its outputs in the same cycle, unchanged.
- R4: Bits leave the buffer in arrival order, behind the bits already held at recentring.
- R5: Without an error, `full_flag` is high exactly while the fill equals the depth and `empty_flag` is high exactly while the fill is zero, never both.
- R6: At full the oscillator step is the nominal step raised by `PPM_OFS` ppm; at empty it is lowered by the same amount. The fill correction is not applied in either state, so a read at empty arrives within 10 cycles of the empty flag rising.
- R7: Otherwise the step is the nominal step plus (fill - depth/2)·2^(ACC_W-LOOP_SH), limited to ±half the nominal step. Each carry out of the accumulator issues one read one cycle later, so a sustained write rate 6.7 % above nominal is tracked without error.
- R8: A write at full with no read in the same cycle is dropped. A read at empty returns no bit. Either event sets the error state, which shows as both flags high.
- R9: The error state holds until an `err_clr` pulse. After the pulse the flags again follow the fill level.
- R10: A change of effective depth code or of placement recentres the buffer: fill and write pointer go to depth/2, the read pointer goes to 0, stored bits and the error state are cleared, and the oscillator phase returns to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| depth_sel | input | 2 | Depth code |
| pin_mode | input | 1 | Restricted strap mode (16/32 only) |
| rx_en | input | 1 | Place buffer in receive stream |
| tx_en | input | 1 | Place buffer in transmit stream (wins) |
| err_clr | input | 1 | Clears the sticky error state |
| rx_in_stb | input | 1 | Receive bit strobe |
| rx_in_bit | input | 1 | Receive bit |
| tx_in_stb | input | 1 | Transmit bit strobe |
| tx_in_bit | input | 1 | Transmit bit |
| rx_out_stb | output | 1 | Receive output strobe |
| rx_out_bit | output | 1 | Receive output bit |
| tx_out_stb | output | 1 | Transmit output strobe |
| tx_out_bit | output | 1 | Transmit output bit |
| full_flag | output | 1 | Buffer full (both high: data error) |
| empty_flag | output | 1 | Buffer empty (both high: data error) |

## Verification
A pointer or fill count that is wrong shows up in the cycle it next matters. The count of zero bits drained after recentring comes out off by some amount, a bit lands out of sequence in the output, or a flag rises early or late. A correction or override term that is wrong is slower to show. Under a sustained mismatched write rate the fill drifts to an edge, and the error encoding latches within a few thousand cycles. A read that reaches an empty buffer at the wrong pace shifts the underflow past its ten-cycle bound.

// File: rtl/jabuf_pkg.sv
package jabuf_pkg;

    typedef enum logic [1:0] {
        PATH_OFF = 2'd0,
        PATH_RX  = 2'd1,
        PATH_TX  = 2'd2
    } path_e;

    typedef struct packed {
        logic [1:0] code;
        path_e      path;
    } cfg_t;

    typedef struct packed {
        logic stb;
        logic dat;
    } bit_t;

    // restricted strap mode keeps only the two smallest depths
    function automatic logic [1:0] eff_code(input logic [1:0] sel, input logic pin);
        return pin ? {1'b0, sel[0]} : sel;
    endfunction

    function automatic path_e pick_path(input logic tx, input logic rx);
        if (tx) return PATH_TX;
        if (rx) return PATH_RX;
        return PATH_OFF;
    endfunction

endpackage

// File: rtl/jabuf_ctrl.sv
module jabuf_ctrl
    import jabuf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] depth_sel,
    input  logic       pin_mode,
    input  logic       rx_en,
    input  logic       tx_en,
    output cfg_t       cfg,
    output logic       recenter
);
    cfg_t cfg_q;

    always_comb begin
        cfg.code = eff_code(depth_sel, pin_mode);
        cfg.path = pick_path(tx_en, rx_en);
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg;
    end

    assign recenter = rst || (cfg != cfg_q) || (cfg.path == PATH_OFF);
endmodule

// File: rtl/jabuf_fifo.sv
module jabuf_fifo
    import jabuf_pkg::*;
#(
    parameter int MIN_DEPTH = 16,
    localparam int MAX_DEPTH = MIN_DEPTH * 8,
    localparam int PW = $clog2(MAX_DEPTH),
    localparam int FW = PW + 1
) (
    input  logic          clk,
    input  logic          recenter,
    input  logic [1:0]    code,
    input  bit_t          wr,
    input  logic          rd,
    input  logic          err_clr,
    output bit_t          q,
    output logic [FW-1:0] fill,
    output logic [FW-1:0] depth,
    output logic          err
);
    logic [MAX_DEPTH-1:0] mem;
    logic [PW-1:0]        wp, rp, mask;
    logic                 rd_ok, wr_ok, ovf, udf;

    assign depth = FW'(MIN_DEPTH) << code;
    assign mask  = PW'(depth - 1'b1);
    assign rd_ok = rd && (fill != '0);
    assign udf   = rd && (fill == '0);
    assign ovf   = wr.stb && (fill == depth) && !rd_ok;
    assign wr_ok = wr.stb && !ovf;

    always_ff @(posedge clk) begin
        if (recenter) begin
            mem  <= '0;
            wp   <= PW'(depth >> 1);
            rp   <= '0;
            fill <= depth >> 1;
            err  <= 1'b0;
            q    <= '0;
        end else begin
            q.stb <= rd_ok;
            if (rd_ok) begin
                q.dat <= mem[rp];
                rp    <= (rp + 1'b1) & mask;
            end
            if (wr_ok) begin
                mem[wp] <= wr.dat;
                wp      <= (wp + 1'b1) & mask;
            end
            fill <= fill + FW'(wr_ok) - FW'(rd_ok);
            err  <= (err && !err_clr) || ovf || udf;
        end
    end
endmodule

// File: rtl/jabuf_nco.sv
module jabuf_nco #(
    parameter int                ACC_W   = 32,
    parameter logic [ACC_W-1:0]  NOM_INC = 32'h2000_0000,
    parameter int                PPM_OFS = 6250,
    parameter int                LOOP_SH = 8,
    parameter int                FW      = 8,
    localparam int               SW      = ACC_W + FW + 2,
    localparam int               SH      = ACC_W - LOOP_SH,
    localparam int               BW      = ACC_W + 20
) (
    input  logic             clk,
    input  logic             hold,
    input  logic [FW-1:0]    fill,
    input  logic [FW-1:0]    depth,
    output logic [ACC_W-1:0] inc,
    output logic             rd_stb
);
    localparam logic [BW-1:0] BUMP_W =
        (BW'(NOM_INC) * BW'(PPM_OFS)) / BW'(1000000);
    localparam logic [ACC_W-1:0] BUMP = BUMP_W[ACC_W-1:0];
    localparam logic signed [SW-1:0] TLIM = $signed(SW'(NOM_INC >> 1));
    localparam logic signed [SW-1:0] NOM_S = $signed(SW'(NOM_INC));

    logic [ACC_W-1:0]        acc;
    logic [ACC_W:0]          sum;
    logic signed [FW:0]      err_s;
    logic signed [SW-1:0]    trim_w, trim_sat, inc_s;
    logic                    at_full, at_empty;

    assign at_full  = (fill == depth);
    assign at_empty = (fill == '0);

    always_comb begin
        err_s  = $signed({1'b0, fill}) - $signed({1'b0, depth >> 1});
        trim_w = SW'(err_s) <<< SH;
        if (trim_w > TLIM)       trim_sat = TLIM;
        else if (trim_w < -TLIM) trim_sat = -TLIM;
        else                     trim_sat = trim_w;
        inc_s = NOM_S + trim_sat;
        if (at_full)       inc = NOM_INC + BUMP;
        else if (at_empty) inc = NOM_INC - BUMP;
        else               inc = inc_s[ACC_W-1:0];
    end

    assign sum = {1'b0, acc} + {1'b0, inc};

    always_ff @(posedge clk) begin
        if (hold) begin
            acc    <= '0;
            rd_stb <= 1'b0;
        end else begin
            acc    <= sum[ACC_W-1:0];
            rd_stb <= sum[ACC_W];
        end
    end
endmodule

// File: rtl/jabuf_top.sv
module jabuf_top
    import jabuf_pkg::*;
#(
    parameter int               MIN_DEPTH = 16,
    parameter int               ACC_W     = 32,
    parameter logic [ACC_W-1:0] NOM_INC   = 32'h2000_0000,
    parameter int               PPM_OFS   = 6250,
    parameter int               LOOP_SH   = 8,
    localparam int              PW        = $clog2(MIN_DEPTH * 8),
    localparam int              FW        = PW + 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] depth_sel,
    input  logic       pin_mode,
    input  logic       rx_en,
    input  logic       tx_en,
    input  logic       err_clr,
    input  logic       rx_in_stb,
    input  logic       rx_in_bit,
    input  logic       tx_in_stb,
    input  logic       tx_in_bit,
    output logic       rx_out_stb,
    output logic       rx_out_bit,
    output logic       tx_out_stb,
    output logic       tx_out_bit,
    output logic       full_flag,
    output logic       empty_flag
);
    cfg_t             cfg;
    logic             recenter;
    bit_t             att_in, att_out;
    logic [FW-1:0]    att_fill, att_depth;
    logic             att_err, rd_stb;
    logic [ACC_W-1:0] nco_inc;

    jabuf_ctrl u_ctrl (
        .clk(clk), .rst(rst), .depth_sel(depth_sel), .pin_mode(pin_mode),
        .rx_en(rx_en), .tx_en(tx_en), .cfg(cfg), .recenter(recenter)
    );

    always_comb begin
        if (cfg.path == PATH_TX) att_in = '{stb: tx_in_stb, dat: tx_in_bit};
        else                     att_in = '{stb: rx_in_stb, dat: rx_in_bit};
    end

    jabuf_fifo #(.MIN_DEPTH(MIN_DEPTH)) u_fifo (
        .clk(clk), .recenter(recenter), .code(cfg.code), .wr(att_in),
        .rd(rd_stb), .err_clr(err_clr), .q(att_out), .fill(att_fill),
        .depth(att_depth), .err(att_err)
    );

    jabuf_nco #(
        .ACC_W(ACC_W), .NOM_INC(NOM_INC), .PPM_OFS(PPM_OFS),
        .LOOP_SH(LOOP_SH), .FW(FW)
    ) u_nco (
        .clk(clk), .hold(recenter), .fill(att_fill), .depth(att_depth),
        .inc(nco_inc), .rd_stb(rd_stb)
    );

    always_comb begin
        rx_out_stb = rx_in_stb;
        rx_out_bit = rx_in_bit;
        tx_out_stb = tx_in_stb;
        tx_out_bit = tx_in_bit;
        if (cfg.path == PATH_RX) begin
            rx_out_stb = att_out.stb;
            rx_out_bit = att_out.dat;
        end else if (cfg.path == PATH_TX) begin
            tx_out_stb = att_out.stb;
            tx_out_bit = att_out.dat;
        end
    end

    assign full_flag  = att_err || (att_fill == att_depth);
    assign empty_flag = att_err || (att_fill == '0);
endmodule

// File: rtl/jabuf_chk.sv
module jabuf_chk #(
    parameter int               FW      = 8,
    parameter int               ACC_W   = 32,
    parameter logic [ACC_W-1:0] NOM_INC = 32'h2000_0000
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_en,
    input logic             tx_en,
    input logic             err_clr,
    input logic             full_flag,
    input logic             empty_flag,
    input logic             recenter,
    input logic [FW-1:0]    fill,
    input logic [FW-1:0]    depth,
    input logic [ACC_W-1:0] inc,
    input logic             rd_stb,
    input logic             out_stb
);
    p_fill_bound_r8: assert property (@(posedge clk) disable iff (rst)
        fill <= depth);

    p_recenter_half_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(recenter) && !recenter) |-> (fill == (depth >> 1)));

    p_boost_full_r6: assert property (@(posedge clk) disable iff (rst)
        (fill == depth && !recenter) |-> (inc > NOM_INC));

    p_slow_empty_r6: assert property (@(posedge clk) disable iff (rst)
        (fill == '0 && !recenter) |-> (inc < NOM_INC));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (full_flag && empty_flag && !err_clr && !recenter) |=> (full_flag && empty_flag));

    p_bypass_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && !tx_en && $past(!rx_en && !tx_en)) |-> (!full_flag && !empty_flag));

    p_read_has_data_r8: assert property (@(posedge clk) disable iff (rst)
        out_stb |-> ($past(fill) != '0));

    p_read_after_carry_r7: assert property (@(posedge clk) disable iff (rst)
        out_stb |-> $past(rd_stb));
endmodule

bind jabuf_top jabuf_chk #(.FW(FW), .ACC_W(ACC_W), .NOM_INC(NOM_INC)) u_chk (
    .clk(clk), .rst(rst), .rx_en(rx_en), .tx_en(tx_en), .err_clr(err_clr),
    .full_flag(full_flag), .empty_flag(empty_flag), .recenter(recenter),
    .fill(att_fill), .depth(att_depth), .inc(nco_inc), .rd_stb(rd_stb),
    .out_stb(att_out.stb)
);

// File: tb/jabuf_top_bench.sv
`timescale 1ns/1ps
module jabuf_top_bench;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst = 1'b1;
    logic [1:0] depth_sel = 2'b00;
    logic       pin_mode = 1'b0, rx_en = 1'b0, tx_en = 1'b0, err_clr = 1'b0;
    logic       rx_in_stb = 1'b0, rx_in_bit = 1'b0, tx_in_stb = 1'b0, tx_in_bit = 1'b0;
    logic       rx_out_stb, rx_out_bit, tx_out_stb, tx_out_bit, full_flag, empty_flag;

    jabuf_top u_jabuf_top (
        .clk(clk), .rst(rst), .depth_sel(depth_sel), .pin_mode(pin_mode),
        .rx_en(rx_en), .tx_en(tx_en), .err_clr(err_clr),
        .rx_in_stb(rx_in_stb), .rx_in_bit(rx_in_bit),
        .tx_in_stb(tx_in_stb), .tx_in_bit(tx_in_bit),
        .rx_out_stb(rx_out_stb), .rx_out_bit(rx_out_bit),
        .tx_out_stb(tx_out_stb), .tx_out_bit(tx_out_bit),
        .full_flag(full_flag), .empty_flag(empty_flag)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // {depth_sel, pin_mode, expected zero bits drained}
    localparam logic [9:0] VEC [0:5] = '{
        {2'b00, 1'b0, 7'd8},  {2'b01, 1'b0, 7'd16}, {2'b10, 1'b0, 7'd32},
        {2'b11, 1'b0, 7'd64}, {2'b11, 1'b1, 7'd16}, {2'b10, 1'b1, 7'd8}
    };

    // receive output monitor
    bit   mon_on = 1'b0;
    int   obs_n = 0;
    logic obs [0:255];
    always @(negedge clk) begin
        #1;
        if (mon_on && rx_out_stb) begin
            if (obs_n < 256) obs[obs_n] = rx_out_bit;
            obs_n = obs_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] d, input logic rx, input logic tx);
        depth_sel = d; pin_mode = 1'b0; rx_en = rx; tx_en = tx;
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
    endtask

    task automatic send(input logic b, input int gap);
        rx_in_stb = 1'b1; rx_in_bit = b;
        tick(1);
        rx_in_stb = 1'b0;
        if (gap > 1) tick(gap - 1);
    endtask

    // counts output strobes of one stream until the empty flag rises
    task automatic drain(output int n, input bit use_tx, input int limit);
        n = 0;
        for (int c = 0; c < limit; c++) begin
            tick(1); #1;
            if (use_tx ? tx_out_stb : rx_out_stb) n++;
            if (empty_flag) break;
        end
    endtask

    initial begin
        #(4 * 190000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        int n;
        int k;
        logic [7:0] pat;

        // reset state, bypass
        do_reset(2'b00, 1'b0, 1'b0);
        tick(1); #1;
        check(!full_flag && !empty_flag, "R3 bypass flags idle", {full_flag, empty_flag}, 0);
        rx_in_stb = 1'b1; rx_in_bit = 1'b1; tx_in_stb = 1'b1; tx_in_bit = 1'b0; #1;
        check(rx_out_stb && rx_out_bit, "R3 bypass rx passthrough", {rx_out_stb, rx_out_bit}, 3);
        check(tx_out_stb && !tx_out_bit, "R3 bypass tx passthrough", {tx_out_stb, tx_out_bit}, 2);
        tick(1);
        rx_in_stb = 1'b0; tx_in_stb = 1'b0;

        // table: depth codes, strap mode, recentring on change
        do_reset(2'b00, 1'b1, 1'b0);
        for (int i = 0; i < 6; i++) begin
            depth_sel = VEC[i][9:8]; pin_mode = VEC[i][7];
            tick(1); #1;
            check(!full_flag && !empty_flag, "R10 flags clear after recentre", {full_flag, empty_flag}, 0);
            drain(n, 1'b0, 3000);
            check(n == int'(VEC[i][6:0]), "R1 R2 drained count", n, int'(VEC[i][6:0]));
            check(empty_flag && !full_flag, "R5 empty only", {full_flag, empty_flag}, 1);
        end

        // arrival order
        do_reset(2'b00, 1'b1, 1'b0);
        pat = 8'b1011_0010;
        obs_n = 0; mon_on = 1'b1;
        for (int i = 7; i >= 0; i--) send(pat[i], 8);
        k = 0;
        while (!empty_flag && k < 2000) begin tick(1); #1; k++; end
        tick(2);
        mon_on = 1'b0;
        check(obs_n == 16, "R4 output bit count", obs_n, 16);
        for (int i = 0; i < 16; i++) begin
            logic e;
            e = (i < 8) ? 1'b0 : pat[15 - i];
            check(obs[i] === e, "R4 output bit order", int'(obs[i]), int'(e));
        end

        // full, overflow, sticky error, clear
        do_reset(2'b00, 1'b1, 1'b0);
        rx_in_stb = 1'b1; rx_in_bit = 1'b1;
        k = 0;
        do begin tick(1); #1; k++; end while (!full_flag && k < 100);
        check(full_flag && !empty_flag, "R5 full only", {full_flag, empty_flag}, 2);
        tick(4); #1;
        check(full_flag && empty_flag, "R8 overflow error", {full_flag, empty_flag}, 3);
        rx_in_stb = 1'b0;
        tick(40); #1;
        check(full_flag && empty_flag, "R9 error sticky", {full_flag, empty_flag}, 3);
        err_clr = 1'b1; tick(1); err_clr = 1'b0; #1;
        check(!full_flag && !empty_flag, "R9 cleared flags follow fill", {full_flag, empty_flag}, 0);

        // empty, underflow within the slowed read period
        k = 0;
        while (!empty_flag && k < 1000) begin tick(1); #1; k++; end
        check(empty_flag && !full_flag, "R5 empty reached", {full_flag, empty_flag}, 1);
        k = 0;
        while (!full_flag && k < 40) begin tick(1); #1; k++; end
        check(k <= 10, "R6 read at empty within bound", k, 10);
        check(full_flag && empty_flag, "R8 underflow error", {full_flag, empty_flag}, 3);

        // depth change clears the error
        depth_sel = 2'b01; tick(1); #1;
        check(!full_flag && !empty_flag, "R10 depth change clears error", {full_flag, empty_flag}, 0);

        // transmit placement, receive passthrough
        tx_en = 1'b1; rx_en = 1'b1;
        tick(1);
        rx_in_stb = 1'b1; rx_in_bit = 1'b0; #1;
        check(rx_out_stb && !rx_out_bit, "R3 rx passthrough while tx attenuated", {rx_out_stb, rx_out_bit}, 2);
        rx_in_stb = 1'b0;
        drain(n, 1'b1, 3000);
        check(n == 16, "R3 tx path drained count", n, 16);

        // sustained fast writer is tracked
        do_reset(2'b01, 1'b1, 1'b0);
        obs_n = 0; mon_on = 1'b1;
        for (int i = 0; i < 400; i++) send(i[0], (i % 2 == 0) ? 7 : 8);
        #1;
        mon_on = 1'b0;
        check(!(full_flag && empty_flag), "R7 no error under rate offset", {full_flag, empty_flag}, 0);
        check(obs_n >= 384 && obs_n <= 416, "R7 output rate tracks input", obs_n, 400);

        done = 1'b1;
        report();
    end
endmodule